// File: doc/BRIEF.md
# Feedback Echo Mixer

This block adds a feedback echo to a stream of signed 16-bit audio samples. A circular store, sized to hold some tens of milliseconds of audio (a depth of roughly 0.05 to 0.1 times the sample rate), keeps one past value per slot. For each accepted sample, the block reads the slot under a single wrapping pointer. It blends the new sample with the stored value using a runtime weight. It writes the blend back into the same slot and then advances the pointer. Because the blend goes back into the store, every echo feeds the next one, and the repeats decay geometrically.

The blend is `floor((x*w + y*(256-w)) / 256)`, saturated to the signed 16-bit range. Here `x` is the incoming sample, `y` is the stored value and `w` is an 8-bit unsigned weight. After reset the block sweeps the whole store to zero before it takes any sample, so the first lap mixes against silence. The input uses a valid/ready handshake and admits one sample at a time. The output holds its value until the consumer takes it.

Top module: `echo_mixer`

## Requirements
- R1: After reset is released, `in_ready` and `out_valid` stay low for exactly DEPTH clock edges while the store is zeroed. `in_ready` is high after edge DEPTH.
- R2: For the first DEPTH samples after reset, the output equals `floor(x*w/256)`, because the stored value is zero.
- R3: Every output equals `floor((x*w + y*(256-w))/256)` clamped to [-32768, 32767]. Here `x` is `in_data` read as two's complement, `w` is `mix_k` read as unsigned (0..255), and `y` is the value stored in the current slot.
- R4: The value written back into a slot is the blended output, not the raw input sample.
- R5: The pointer advances by one slot per sample and wraps modulo DEPTH. Sample n therefore reads the value written by sample n-DEPTH; with `w`=0 it reproduces that earlier output.
- R6: The weight is captured with the sample in the accepting cycle. Changes on `mix_k` while a sample is being processed do not alter its result.
- R7: `in_ready` is low from the cycle after an acceptance until the output handshake has completed. An `in_valid` pulse in that window is ignored: no extra sample is taken.
- R8: `out_valid` rises on the second rising edge counting the accepting edge as the first. While `out_ready` is low, `out_valid` and `out_data` stay unchanged. After the handshake edge, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed input sample |
| mix_k | input | 8 | Unsigned weight of the new sample, in 1/256 steps |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | 16 | Signed blended sample |

## Verification
The hardest situation to reach from the ports is a slot being read a second and third time. Only then does the feedback path show whether the written value was the blend or the raw sample, and whether the pointer wraps at the right place. The bench builds the store with a depth of 16 so that many laps fit in a short run. It keeps a reference ring of its own, and it inserts zero-weight samples after several laps so the output must replay exactly the value produced one lap before. Random stalls on `out_ready`, together with weight changes and stray `in_valid` pulses during those stalls, cover the capture and blocking rules.

// File: rtl/echo_pkg.sv
package echo_pkg;

    localparam int SMP_W = 16;
    localparam int WGT_W = 8;
    localparam int ACC_W = SMP_W + WGT_W + 3;

    typedef logic signed [SMP_W-1:0] sample_t;
    typedef logic [WGT_W-1:0]        weight_t;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_MIX   = 2'd2,
        ST_HOLD  = 2'd3
    } phase_t;

    typedef struct packed {
        sample_t smp;
        weight_t wgt;
    } job_t;

    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (SMP_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(1 <<< (SMP_W-1));

    // Weighted blend: (fresh*w + stored*(2^WGT_W - w)) >>> WGT_W, clamped.
    function automatic sample_t blend(input sample_t fresh, input sample_t stored,
                                      input weight_t w);
        logic signed [ACC_W-1:0] wa;
        logic signed [ACC_W-1:0] wb;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] scaled;
        wa     = ACC_W'({1'b0, w});
        wb     = ACC_W'(1 <<< WGT_W) - wa;
        acc    = ACC_W'(fresh) * wa + ACC_W'(stored) * wb;
        scaled = acc >>> WGT_W;
        if (scaled > SAT_HI)      return SAT_HI[SMP_W-1:0];
        else if (scaled < SAT_LO) return SAT_LO[SMP_W-1:0];
        else                      return scaled[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/echo_ptr.sv
module echo_ptr #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic          at_last
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign at_last = (ptr == LAST);

    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (adv)     ptr <= at_last ? '0 : ptr + 1'b1;
    end

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (ptr == '0));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST);

endmodule

// File: rtl/echo_store.sv
module echo_store #(
    parameter int DEPTH = 512,
    parameter int W     = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  rd_q,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_d
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[addr] <= wr_d;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= cells[addr];
    end

endmodule

// File: rtl/echo_mixer.sv
module echo_mixer
    import echo_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [SMP_W-1:0] in_data,
    input  logic [WGT_W-1:0]        mix_k,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [SMP_W-1:0] out_data
);

    phase_t  phase;
    job_t    job;
    sample_t stored;
    sample_t mixed;
    logic [AW-1:0] slot;
    logic    slot_last;
    logic    take;
    logic    wr_en;
    sample_t wr_d;

    assign in_ready = (phase == ST_IDLE);
    assign take     = in_ready && in_valid;
    assign wr_en    = (phase == ST_CLEAR) || (phase == ST_MIX);
    assign mixed    = blend(job.smp, stored, job.wgt);
    assign wr_d     = (phase == ST_MIX) ? mixed : '0;

    echo_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (wr_en),
        .ptr     (slot),
        .at_last (slot_last)
    );

    echo_store #(.DEPTH(DEPTH), .W(SMP_W)) u_store (
        .clk   (clk),
        .rd_en (take),
        .addr  (slot),
        .rd_q  (stored),
        .wr_en (wr_en),
        .wr_d  (wr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_CLEAR;
            job       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            unique case (phase)
                ST_CLEAR: if (slot_last) phase <= ST_IDLE;
                ST_IDLE: if (in_valid) begin
                    job   <= '{smp: in_data, wgt: mix_k};
                    phase <= ST_MIX;
                end
                ST_MIX: begin
                    out_data  <= mixed;
                    out_valid <= 1'b1;
                    phase     <= ST_HOLD;
                end
                ST_HOLD: if (out_ready) begin
                    out_valid <= 1'b0;
                    phase     <= ST_IDLE;
                end
                default: phase <= ST_CLEAR;
            endcase
        end
    end

    // R1
    clear_block_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_CLEAR) |-> (!in_ready && !out_valid));

    // R7
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid);

    // R7
    accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !in_ready);

    // R8
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ##1 out_valid);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3
    blend_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_MIX) |->
            ((mixed >= job.smp || mixed >= stored) &&
             (mixed <= job.smp || mixed <= stored)));

endmodule

// File: tb/tb_echo_mixer.sv
module tb_echo_mixer;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic signed [15:0] in_data = '0;
    logic [7:0]  mix_k = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic signed [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int ring [DEPTH];
    int rp = 0;
    int sent = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    echo_mixer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .mix_k(mix_k),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (sample %0d)", rq, act, exp, sent);
        end
    endtask

    function automatic int ref_mix(input int x, input int y, input int w);
        int p;
        p = x * w + y * (256 - w);
        p = p >>> 8;
        if (p > 32767)  p = 32767;
        if (p < -32768) p = -32768;
        return p;
    endfunction

    // Sends one sample, checks timing, holding and value, updates the model.
    task automatic send(input int x, input int w, input int stall, input string rq);
        int exp;
        while (!in_ready) @(negedge clk);
        in_data  = 16'(x);
        mix_k    = 8'(w);
        in_valid = 1'b1;
        exp = ref_mix(x, ring[rp], w);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        mix_k = 8'($urandom_range(255));
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
        chk(int'(out_data) == exp, rq, int'(out_data), exp);
        for (int i = 0; i < stall; i++) begin
            // R6: weight churn, R7: stray valid while busy
            mix_k    = 8'($urandom_range(255));
            in_valid = ($urandom_range(1) == 1);
            in_data  = 16'($urandom);
            @(negedge clk);
            chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
            chk(int'(out_data) == exp, "R6", int'(out_data), exp);
            chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R8", int'(in_ready), 1);
        ring[rp] = exp;
        rp = (rp + 1) % DEPTH;
        sent++;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        for (int i = 0; i < DEPTH; i++) ring[i] = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        rst = 1'b0;
        in_valid = 1'b1;
        repeat (DEPTH - 1) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

        // R2: first lap mixes against silence, edge weights and extremes
        send(32767, 255, 0, "R2");
        send(-32768, 255, 1, "R2");
        send(-32768, 0, 0, "R2");
        send(12345, 128, 2, "R2");
        send(-1, 1, 0, "R2");
        for (int i = 5; i < DEPTH; i++)
            send(int'($signed(16'($urandom))), $urandom_range(255), $urandom_range(3), "R2");

        // R4: second lap reads back blends, not raw samples
        for (int i = 0; i < DEPTH; i++)
            send(int'($signed(16'($urandom))), $urandom_range(1, 254), $urandom_range(2), "R4");

        // R5: zero weight replays the output from one lap before
        for (int i = 0; i < DEPTH + 3; i++)
            send(int'($signed(16'($urandom))), 0, $urandom_range(2), "R5");

        // R3: random traffic across many laps
        for (int i = 0; i < 400; i++)
            send(int'($signed(16'($urandom))), $urandom_range(255), $urandom_range(4), "R3");

        // R3: saturated corners after feedback has built up
        send(32767, 128, 0, "R3");
        send(-32768, 255, 0, "R3");
        send(0, 255, 0, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule